// File: doc/BRIEF.md
# Delta-Sigma ADC Serial Readout Controller

This block is the host-side reader for a three-wire delta-sigma converter. It owns the converter's chip select and serial clock, and it listens on a single shared line. That line first acts as a busy/ready indicator and then carries the result bits. After a start request the controller pulls chip select low and watches the shared line. While the line is high a conversion is running. Once the line reads low, the controller clocks in a 24-bit frame.

Each frame opens with two range bits, low-overflow then high-overflow. The controller uses them to pick how the remaining 22 bits are read. Within range, the 22 bits are a two's complement code. Out of range, the low-overflow bit becomes the sign of a 23-bit code. If both range bits are set, the transfer is corrupt and is reported as an error instead of data. Results are sign-extended to 24 bits and presented in parallel with a one-cycle strobe.

In single mode one frame is read and chip select is released. In continuous mode chip select stays low and the controller goes straight back to polling. The serial clock rate is set by a divider input. A poll timer gives up if the converter never signals ready.

Top module: `dsadc_rd_ctrl`

## Requirements
- R1: Out of reset and when idle, cs_n is 1, sck is 0, all strobes are 0 and res_data, res_ovh and res_ovl are 0. A start sampled high while idle drives cs_n to 0 on the next cycle. A start sampled while cs_n is 0 has no effect.
- R2: While polling, sck stays 0. When sdo_rdy is sampled 0, the frame transfer begins on the following cycle.
- R3: During a frame, sck begins low and each of its half periods lasts sck_div+1 system clocks. A frame has exactly 24 rising sck edges. The bit taken on each rising edge is the sdo_rdy value sampled at the system clock edge that drives sck high.
- R4: Wire order: the first bit received is the low-overflow flag (frame bit 23), the second is the high-overflow flag (frame bit 22), then frame bits 21 down to 0, most significant first.
- R5: If both flags are 0, res_data is bits 21..0 sign-extended from bit 21. res_valid is 1 for exactly one cycle: the cycle in which sck first reads 0 after the 24th rising edge.
- R6: If exactly one flag is set, res_data is the 23-bit two's complement value {low-overflow, bits 21..0} sign-extended to 24 bits, with no clamping. res_valid pulses as in R5.
- R7: If both flags are set, res_err pulses for one cycle at the time res_valid would have pulsed. res_valid stays 0 and res_data keeps its previous value.
- R8: With mode_cont sampled 0 at the end of a frame, cs_n goes to 1 in the same cycle as the result strobe. With mode_cont sampled 1, cs_n stays 0, polling resumes and the poll timer restarts.
- R9: If sdo_rdy is sampled 1 on max(tmo_limit,1) consecutive polling cycles, res_tmo pulses for one cycle and cs_n goes to 1 in that same cycle.
- R10: res_ovh and res_ovl show frame bits 22 and 23 of the most recently completed frame, error frames included, and hold them until the next frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an acquisition when idle |
| mode_cont | input | 1 | 1 = continuous acquisition, 0 = single |
| sck_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| tmo_limit | input | TMO_W | Ready-poll timeout in polling cycles |
| sdo_rdy | input | 1 | Shared ready/data line from the converter |
| cs_n | output | 1 | Converter chip select, active low |
| sck | output | 1 | Serial clock to the converter |
| res_data | output | 24 | Sign-extended conversion result |
| res_valid | output | 1 | One-cycle strobe for a valid result |
| res_ovh | output | 1 | High-overflow flag of the last frame |
| res_ovl | output | 1 | Low-overflow flag of the last frame |
| res_err | output | 1 | One-cycle strobe for a frame with both flags set |
| res_tmo | output | 1 | One-cycle strobe for a ready-poll timeout |

## Verification
Several rules are checked on every cycle by properties:
- sck stays low whenever chip select is high.
- The valid and error strobes never coincide, and each lasts a single cycle.
- An error frame leaves the data output untouched.
- The upper result bits agree with the range flags.
- Chip select is released together with a single-mode strobe or a timeout.

Other behaviour only the bench's scenarios can show:
- The exact serial clock timing for several divider settings.
- The wire bit order and the decoded values of in-range, overflow and error frames.
- Back-to-back continuous frames with no release of chip select.
- The timeout count for limits 25 and 0.
- A start pulse ignored mid-frame.

// File: rtl/dsadc_rd_pkg.sv
package dsadc_rd_pkg;
  // Serial frame: two range flags followed by a 22-bit code
  localparam int FRAME_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_POLL  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;
endpackage

// File: rtl/dsadc_rd_sckgen.sv
module dsadc_rd_sckgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             wrap;

  assign wrap = run && (cnt_q == half_div);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck  = sck_q;
  assign rise = wrap && !sck_q;
  assign fall = wrap && sck_q;
endmodule

// File: rtl/dsadc_rd_shreg.sv
module dsadc_rd_shreg #(
  parameter int W     = 24,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             din,
  output logic [W-1:0]     frame,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0]     frame_q, frame_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             frame_en;

  assign frame_en = shift_en;

  always_comb begin
    frame_d = {frame_q[W-2:0], din};
    count_d = count_q;
    if (clr)
      count_d = '0;
    else if (shift_en)
      count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      count_q <= '0;
    end else begin
      if (frame_en) frame_q <= frame_d;
      count_q <= count_d;
    end
  end

  assign frame = frame_q;
  assign count = count_q;
endmodule

// File: rtl/dsadc_rd_timer.sv
module dsadc_rd_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic [TW:0]   cnt_inc;

  // one bit wider so the increment never wraps before the compare
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign expire  = tick && (cnt_inc >= {1'b0, limit});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (tick)
      cnt_d = cnt_inc[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dsadc_rd_decode.sv
module dsadc_rd_decode #(
  parameter int W = 24
) (
  input  logic [W-1:0] frame,
  output logic [W-1:0] value,
  output logic         ovh,
  output logic         ovl,
  output logic         err
);
  logic sgn;

  assign ovl = frame[W-1];
  assign ovh = frame[W-2];
  assign err = ovl && ovh;
  // in range: sign is the code's top bit; out of range: low-overflow flag is the sign
  assign sgn   = (ovl || ovh) ? ovl : frame[W-3];
  assign value = {sgn, sgn, frame[W-3:0]};
endmodule

// File: rtl/dsadc_rd_ctrl.sv
module dsadc_rd_ctrl
  import dsadc_rd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int TMO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode_cont,
  input  logic [DIV_W-1:0]   sck_div,
  input  logic [TMO_W-1:0]   tmo_limit,
  input  logic               sdo_rdy,
  output logic               cs_n,
  output logic               sck,
  output logic [FRAME_W-1:0] res_data,
  output logic               res_valid,
  output logic               res_ovh,
  output logic               res_ovl,
  output logic               res_err,
  output logic               res_tmo
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  rd_state_e state_q, state_d;

  logic               sck_run, sck_rise, sck_fall;
  logic               sh_clr;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;
  logic               tmr_clr, tmr_tick, tmr_expire;
  logic [FRAME_W-1:0] dec_value;
  logic               dec_ovh, dec_ovl, dec_err;
  logic               frame_done, tmo_hit;

  logic [FRAME_W-1:0] data_q, data_d;
  logic               data_en;
  logic               valid_q, valid_d;
  logic               err_q, err_d;
  logic               tmo_q, tmo_d;
  logic               ovh_q, ovl_q, flag_en;

  dsadc_rd_sckgen #(.DIV_W(DIV_W)) u_sckgen (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (sck_run),
    .half_div (sck_div),
    .sck      (sck),
    .rise     (sck_rise),
    .fall     (sck_fall)
  );

  dsadc_rd_shreg #(.W(FRAME_W), .CNT_W(CNT_W)) u_shreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sh_clr),
    .shift_en (sck_rise),
    .din      (sdo_rdy),
    .frame    (frame),
    .count    (bit_cnt)
  );

  dsadc_rd_timer #(.TW(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tmr_clr),
    .tick   (tmr_tick),
    .limit  (tmo_limit),
    .expire (tmr_expire)
  );

  dsadc_rd_decode #(.W(FRAME_W)) u_decode (
    .frame (frame),
    .value (dec_value),
    .ovh   (dec_ovh),
    .ovl   (dec_ovl),
    .err   (dec_err)
  );

  assign sck_run  = (state_q == ST_SHIFT);
  assign sh_clr   = (state_q == ST_POLL);
  assign tmr_clr  = (state_q != ST_POLL);
  assign tmr_tick = (state_q == ST_POLL) && sdo_rdy;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    frame_done = 1'b0;
    tmo_hit    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) state_d = ST_POLL;                          // R1
      end
      ST_POLL: begin
        if (!sdo_rdy) begin
          state_d = ST_SHIFT;                                  // R2
        end else if (tmr_expire) begin
          state_d = ST_IDLE;                                   // R9
          tmo_hit = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (sck_fall && (bit_cnt == CNT_W'(FRAME_W))) begin
          frame_done = 1'b1;
          state_d    = mode_cont ? ST_POLL : ST_IDLE;          // R8
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // result register inputs
  always_comb begin
    valid_d = frame_done && !dec_err;
    err_d   = frame_done && dec_err;                           // R7
    tmo_d   = tmo_hit;
    data_en = frame_done && !dec_err;
    data_d  = dec_value;
    flag_en = frame_done;                                      // R10
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      tmo_q   <= 1'b0;
      data_q  <= '0;
      ovh_q   <= 1'b0;
      ovl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      err_q   <= err_d;
      tmo_q   <= tmo_d;
      if (data_en) data_q <= data_d;
      if (flag_en) begin
        ovh_q <= dec_ovh;
        ovl_q <= dec_ovl;
      end
    end
  end

  assign cs_n      = (state_q == ST_IDLE);
  assign res_data  = data_q;
  assign res_valid = valid_q;
  assign res_err   = err_q;
  assign res_tmo   = tmo_q;
  assign res_ovh   = ovh_q;
  assign res_ovl   = ovl_q;
endmodule

// File: rtl/dsadc_rd_chk.sv
module dsadc_rd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_cont,
  input logic        cs_n,
  input logic        sck,
  input logic [23:0] res_data,
  input logic        res_valid,
  input logic        res_ovh,
  input logic        res_ovl,
  input logic        res_err,
  input logic        res_tmo
);
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R1
  AST_SCK_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(sck) |-> !cs_n); // R3
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid); // R5
  AST_INRANGE_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && !res_ovh && !res_ovl) |-> (res_data[23] == res_data[21] && res_data[22] == res_data[21])); // R5
  AST_OVERFLOW_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (res_valid && (res_ovh || res_ovl)) |-> (res_data[23] == res_ovl && res_data[22] == res_ovl)); // R6
  AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n) !(res_valid && res_err)); // R7
  AST_ERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) res_err |-> (res_ovh && res_ovl)); // R7
  AST_ERR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) res_err |-> $stable(res_data)); // R7
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ((res_valid || res_err) && !$past(mode_cont)) |-> cs_n); // R8
  AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) res_tmo |-> cs_n); // R9
endmodule

bind dsadc_rd_ctrl dsadc_rd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_cont (mode_cont),
  .cs_n      (cs_n),
  .sck       (sck),
  .res_data  (res_data),
  .res_valid (res_valid),
  .res_ovh   (res_ovh),
  .res_ovl   (res_ovl),
  .res_err   (res_err),
  .res_tmo   (res_tmo)
);

// File: tb/dsadc_rd_ctrl_tb.sv
module dsadc_rd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int TMO_W      = 12;
  localparam int NFR        = 10;

  logic             clk, rst_n, start, mode_cont, sdo_rdy;
  logic [DIV_W-1:0] sck_div;
  logic [TMO_W-1:0] tmo_limit;
  logic             cs_n, sck, res_valid, res_ovh, res_ovl, res_err, res_tmo;
  logic [23:0]      res_data;

  dsadc_rd_ctrl #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_cont(mode_cont),
    .sck_div(sck_div), .tmo_limit(tmo_limit), .sdo_rdy(sdo_rdy),
    .cs_n(cs_n), .sck(sck), .res_data(res_data), .res_valid(res_valid),
    .res_ovh(res_ovh), .res_ovl(res_ovl), .res_err(res_err), .res_tmo(res_tmo)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  logic [23:0] frames [NFR];

  task automatic chk(input logic ok, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // value of a frame from the numeric rules: code minus 2^22 when the sign applies
  function automatic logic [23:0] ref_value(input logic [23:0] f);
    int v;
    logic s;
    s = (f[23] || f[22]) ? f[23] : f[21];
    v = int'({10'd0, f[21:0]});
    if (s) v = v - 4194304;
    return v[23:0];
  endfunction

  // ---------------- reference model (updated on rising edge) ----------------
  int m_state, m_div, m_sck, m_bits, m_tmo, m_idx, lim;
  logic e_valid, e_err, e_tmo, e_ovh, e_ovl;
  logic [23:0] e_data, mf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_div = 0; m_sck = 0; m_bits = 0; m_tmo = 0; m_idx = 0;
      e_valid = 0; e_err = 0; e_tmo = 0; e_ovh = 0; e_ovl = 0; e_data = '0;
    end else begin
      e_valid = 0; e_err = 0; e_tmo = 0;
      if (m_state == 0) begin
        if (start) begin m_state = 1; m_tmo = 0; end
      end else if (m_state == 1) begin
        if (!sdo_rdy) begin
          m_state = 2; m_div = 0; m_sck = 0; m_bits = 0;
        end else begin
          lim = (tmo_limit == 0) ? 1 : int'(tmo_limit);
          m_tmo++;
          if (m_tmo >= lim) begin m_state = 0; e_tmo = 1; end
        end
      end else begin
        if (m_div < int'(sck_div)) m_div++;
        else begin
          m_div = 0;
          if (m_sck == 0) begin m_sck = 1; m_bits++; end
          else begin
            m_sck = 0;
            if (m_bits == 24) begin
              mf = frames[m_idx]; m_idx++;
              e_ovl = mf[23]; e_ovh = mf[22];
              if (mf[23] && mf[22]) e_err = 1;
              else begin e_valid = 1; e_data = ref_value(mf); end
              m_state = mode_cont ? 1 : 0;
              m_tmo = 0;
            end
          end
        end
      end
    end
  end

  // ---------------- converter model and per-cycle compare (falling edge) ----------------
  int dev_phase = 0, dev_cnt = 0, dev_bit = 0, dev_idx = 0, conv_delay = 5;
  logic dev_sck_prev = 1'b0;
  logic [23:0] dev_frame;
  logic compare_on = 1'b0;

  always @(negedge clk) begin
    if (compare_on && rst_n) begin
      chk(cs_n === (m_state == 0), "R1/R8/R9 cs_n", {23'd0, cs_n}, {23'd0, m_state == 0});
      chk(sck === (m_sck == 1), "R2/R3 sck", {23'd0, sck}, {23'd0, m_sck == 1});
      chk(res_valid === e_valid, "R5/R6 res_valid", {23'd0, res_valid}, {23'd0, e_valid});
      chk(res_err === e_err, "R7 res_err", {23'd0, res_err}, {23'd0, e_err});
      chk(res_tmo === e_tmo, "R9 res_tmo", {23'd0, res_tmo}, {23'd0, e_tmo});
      chk(res_data === e_data, "R4/R5/R6 res_data", res_data, e_data);
      chk({res_ovl, res_ovh} === {e_ovl, e_ovh}, "R10 flags", {22'd0, res_ovl, res_ovh}, {22'd0, e_ovl, e_ovh});
    end
    if (cs_n) begin
      dev_phase = 0; sdo_rdy = 1'b1;
    end else if (dev_phase == 0) begin
      dev_cnt = conv_delay; dev_phase = 1; sdo_rdy = 1'b1;
    end else if (dev_phase == 1) begin
      if (dev_cnt == 0) begin sdo_rdy = 1'b0; dev_phase = 2; end
      else dev_cnt--;
    end else if (dev_phase == 2) begin
      dev_frame = frames[dev_idx]; dev_idx++;
      dev_bit = 23; sdo_rdy = dev_frame[23]; dev_phase = 3;
    end else if (dev_sck_prev && !sck) begin
      if (dev_bit == 0) begin
        dev_phase = 1; dev_cnt = conv_delay; sdo_rdy = 1'b1;
      end else begin
        dev_bit--; sdo_rdy = dev_frame[dev_bit];
      end
    end
    dev_sck_prev = sck;
  end

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic wait_result(output logic got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (res_valid || res_err) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_single(input int div, input logic exp_err, input logic [23:0] exp, input string tag, input logic poke);
    logic got;
    logic [23:0] prev;
    prev = res_data;
    @(negedge clk); sck_div = DIV_W'(div); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1;                      // R1: start while busy is ignored
      @(negedge clk); start = 1'b0;
    end
    wait_result(got);
    chk(got, {tag, " strobe seen"}, {23'd0, got}, 24'd1);
    chk(res_err === exp_err, {tag, " error strobe"}, {23'd0, res_err}, {23'd0, exp_err});
    chk(res_data === (exp_err ? prev : exp), {tag, " data"}, res_data, exp_err ? prev : exp);
    chk(cs_n === 1'b1, "R8 single release with strobe", {23'd0, cs_n}, 24'd1);
    repeat (10) @(negedge clk);
    chk(cs_n === 1'b1, "R1 stays idle after poke", {23'd0, cs_n}, 24'd1);
  endtask

  initial begin
    logic got;
    int cnt;
    frames[0] = 24'h0ABCDE; frames[1] = 24'h3FFFFF; frames[2] = 24'h200000;
    frames[3] = 24'h600010; frames[4] = 24'h9FFFF0; frames[5] = 24'hC12345;
    frames[6] = 24'h1FFFFF; frames[7] = 24'h812345; frames[8] = 24'h000001;
    frames[9] = 24'h155555;
    rst_n = 1'b0; start = 1'b0; mode_cont = 1'b0; sck_div = '0; tmo_limit = 12'd200;
    sdo_rdy = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R1 reset cs_n/sck", {22'd0, cs_n, sck}, 24'd2);
    chk(res_valid === 1'b0 && res_err === 1'b0 && res_tmo === 1'b0, "R1 reset strobes",
        {21'd0, res_valid, res_err, res_tmo}, 24'd0);
    chk(res_data === 24'd0 && res_ovh === 1'b0 && res_ovl === 1'b0, "R1 reset data", res_data, 24'd0);
    rst_n = 1'b1;
    compare_on = 1'b1;
    repeat (2) @(negedge clk);

    run_single(0, 1'b0, 24'h0ABCDE, "R4/R5 positive in range", 1'b0);
    run_single(2, 1'b0, 24'hFFFFFF, "R3/R5 minus one", 1'b1);
    run_single(3, 1'b0, 24'hE00000, "R5 most negative", 1'b0);
    run_single(1, 1'b0, 24'h200010, "R6 high overflow no clamp", 1'b0);
    chk(res_ovh === 1'b1 && res_ovl === 1'b0, "R10 high flag", {22'd0, res_ovl, res_ovh}, 24'd1);
    run_single(0, 1'b0, 24'hDFFFF0, "R6 low overflow", 1'b0);
    run_single(0, 1'b1, 24'h0, "R7 both flags error", 1'b0);
    chk(res_ovh === 1'b1 && res_ovl === 1'b1, "R10 error flags held", {22'd0, res_ovl, res_ovh}, 24'd3);

    // continuous mode: three frames, chip select held
    mode_cont = 1'b1; sck_div = 8'd1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_result(got);
    chk(res_data === 24'h1FFFFF, "R8 continuous frame 1", res_data, 24'h1FFFFF);
    chk(cs_n === 1'b0, "R8 continuous keeps select", {23'd0, cs_n}, 24'd0);
    cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (cs_n) cnt++;
      if (res_valid || res_err) break;
    end
    chk(res_data === 24'hC12345, "R6/R8 continuous frame 2", res_data, 24'hC12345);
    chk(cnt == 0, "R8 no release between frames", cnt[23:0], 24'd0);
    mode_cont = 1'b0;
    wait_result(got);
    chk(res_data === 24'h000001, "R8 last continuous frame", res_data, 24'h000001);
    chk(cs_n === 1'b1, "R8 release after mode drop", {23'd0, cs_n}, 24'd1);
    repeat (5) @(negedge clk);

    // timeout
    conv_delay = 400; tmo_limit = 12'd25;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 1;
    while (!res_tmo && cnt < 300) begin @(negedge clk); cnt++; end
    chk(cnt == 26, "R9 timeout after limit samples", cnt[23:0], 24'd26);
    chk(cs_n === 1'b1, "R9 release on timeout", {23'd0, cs_n}, 24'd1);
    repeat (3) @(negedge clk);
    tmo_limit = 12'd0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cnt = 1;
    while (!res_tmo && cnt < 300) begin @(negedge clk); cnt++; end
    chk(cnt == 2, "R9 zero limit acts as one", cnt[23:0], 24'd2);
    repeat (3) @(negedge clk);

    conv_delay = 3; tmo_limit = 12'd200;
    run_single(4, 1'b0, 24'h155555, "R2/R3 recovery after timeout", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule